// File: doc/BRIEF.md
# Smooth Clock Ramp-Up Sequencer

This block takes a multi-domain clock system from oscillator operation up to full PLL speed without a sudden step in current draw. After a start pulse it performs a fixed, ordered series of writes to three control registers: a clock-source select register and two divider registers. After each write it waits for a timed dwell before making the next one. Division ratios fall by powers of two, and only one domain group moves at a time. The bus and peripheral group ramps first; the external bus group ramps after it has finished.

Each divider field is a 4-bit nibble that divides by its value plus one. The first divider register (`diva`) carries the bus clock ratio in bits 7:4 and the peripheral clock ratio in bits 3:0. The second divider register (`divb`) carries the external bus clock ratio. The source-select codes used are 0x00 (oscillator, PLL off; reset value), 0x34 (PLL enabled, oscillator still the source) and 0x36 (PLL is the source). One dwell unit equals `UNIT_CYC` reference clock cycles.

Top module: `clk_ramp_seq`

## Requirements
- R1: After reset, `src_sel` is 0x00, `diva` and `divb` are 0xFF (every domain divides by 16), `busy`, `done` and all three write strobes are low.
- R2: A start pulse sampled while idle raises `busy` at that clock edge, and the first write appears in the same cycle. Writes occur only while `busy` is high.
- R3: The sequence opens with these writes: `src_sel`=0x34, then `diva`=0xFF, then `divb`=0xFF, on three consecutive cycles. A dwell of 4 units follows, then `src_sel`=0x36, then another dwell of 4 units.
- R4: `diva` then receives 0x77, 0x33, 0x11 and 0x01 in that order. The dwells after these writes are 8, 8, 16 and 16 units.
- R5: After the `diva` ramp has finished, `divb` receives 0x77, 0x33, 0x11 and 0x01. The dwells after these writes are 8, 8, 16 and 16 units.
- R6: A write whose dwell is N units is followed by the next write exactly 1 + N*`UNIT_CYC` cycles later.
- R7: Each write is a single-cycle strobe on exactly one register, and its data appears on that register's output in the same cycle. Outside a strobe, a register output holds its value.
- R8: `done` rises, and `busy` falls, 1 + 16*`UNIT_CYC` cycles after the last write. `done` then stays high until the next accepted start, which clears it at that edge.
- R9: A start pulse arriving while `busy` is high is ignored. The write order, the data and the timing stay unchanged.
- R10: At the end, `src_sel` is 0x36 and `diva` is 0x01 (bus clock undivided, peripheral clock divided by 2). `divb` is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled at each rising edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until the next start |
| src_sel | output | 8 | Clock-source select register value |
| src_wr | output | 1 | Single-cycle write strobe for `src_sel` |
| diva | output | 8 | Bus (7:4) / peripheral (3:0) divider register |
| diva_wr | output | 1 | Single-cycle write strobe for `diva` |
| divb | output | 8 | External bus divider register |
| divb_wr | output | 1 | Single-cycle write strobe for `divb` |

## Verification
The first write is due in the cycle that follows the edge which samples `start`. Each later write is due 1 + N*`UNIT_CYC` cycles after the write before it, where N is that earlier write's dwell in units. `done` is due 1 + 16*`UNIT_CYC` cycles after the twelfth write. When the bench launches a sequence, its driver turns these rules into absolute cycle numbers and queues one entry for each expected write. The monitor samples on the falling clock edge and compares register, data and the cycle number of every strobe it sees against the head of the queue. An early, late, extra or missing write is therefore reported at the cycle where it differs.

// File: rtl/clk_ramp_pkg.sv
package clk_ramp_pkg;

    localparam int NUM_STEPS = 12;
    localparam int STEP_W    = 4;
    localparam int UNIT_W    = 5;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SRC  = 2'd1,
        TGT_DIVA = 2'd2,
        TGT_DIVB = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [7:0]        data;
        logic [UNIT_W-1:0] units;
    } step_t;

    localparam logic [7:0] SRC_OSC     = 8'h00;
    localparam logic [7:0] SRC_PLL_ON  = 8'h34;
    localparam logic [7:0] SRC_PLL_SEL = 8'h36;
    localparam logic [7:0] DIV_SLOWEST = 8'hFF;

    // Ramp entries: steps 4..7 move diva, steps 8..11 move divb.
    // Each nibble halves its ratio (F->7->3->1); the last entry leaves
    // the low nibble at 1 so the peripheral domain keeps dividing by 2.
    function automatic step_t step_at(input logic [STEP_W-1:0] idx);
        step_t       s;
        logic [3:0]  rel;
        logic [1:0]  pos;
        logic [3:0]  nib;
        s   = '{tgt: TGT_NONE, data: 8'h00, units: '0};
        rel = idx - 4'd4;
        pos = rel[1:0];
        nib = 4'hF >> (pos + 2'd1);
        case (idx)
            4'd0: s = '{tgt: TGT_SRC,  data: SRC_PLL_ON,  units: 5'd0};
            4'd1: s = '{tgt: TGT_DIVA, data: DIV_SLOWEST, units: 5'd0};
            4'd2: s = '{tgt: TGT_DIVB, data: DIV_SLOWEST, units: 5'd4};
            4'd3: s = '{tgt: TGT_SRC,  data: SRC_PLL_SEL, units: 5'd4};
            default: begin
                if (idx < 4'(NUM_STEPS)) begin
                    s.tgt   = rel[2] ? TGT_DIVB : TGT_DIVA;
                    s.data  = (pos == 2'd3) ? 8'h01 : {nib, nib};
                    s.units = pos[1] ? 5'd16 : 5'd8;
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/clk_ramp_dwell.sv
module clk_ramp_dwell #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    assert_dwell_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    assert_dwell_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

    assert_dwell_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/clk_ramp_step_dec.sv
module clk_ramp_step_dec
    import clk_ramp_pkg::*;
#(
    parameter int UNIT_CYC = 4,
    parameter int CNT_W    = 7
) (
    input  logic [STEP_W-1:0] idx,
    output tgt_e              tgt,
    output logic [7:0]        data,
    output logic [CNT_W-1:0]  dwell_cyc
);

    step_t st;

    always_comb begin
        st        = step_at(idx);
        tgt       = st.tgt;
        data      = st.data;
        dwell_cyc = CNT_W'(int'(st.units) * UNIT_CYC);
    end

endmodule

// File: rtl/clk_ramp_seq.sv
module clk_ramp_seq
    import clk_ramp_pkg::*;
#(
    parameter int UNIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic [7:0] src_sel,
    output logic       src_wr,
    output logic [7:0] diva,
    output logic       diva_wr,
    output logic [7:0] divb,
    output logic       divb_wr
);

    localparam int MAX_UNITS = 16;
    localparam int CNT_W     = $clog2(MAX_UNITS * UNIT_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [7:0]        src;
        logic [7:0]        diva;
        logic [7:0]        divb;
        logic              src_wr;
        logic              diva_wr;
        logic              divb_wr;
    } seq_t;

    localparam seq_t SEQ_RST = '{busy: 1'b0, done: 1'b0, step: '0,
                                 src: SRC_OSC, diva: DIV_SLOWEST, divb: DIV_SLOWEST,
                                 src_wr: 1'b0, diva_wr: 1'b0, divb_wr: 1'b0};

    seq_t              seq_d, seq_q;
    logic [STEP_W-1:0] idx;
    tgt_e              dec_tgt;
    logic [7:0]        dec_data;
    logic [CNT_W-1:0]  dec_dwell;
    logic              dw_load;
    logic              dw_zero;

    assign idx = seq_q.busy ? seq_q.step : '0;

    clk_ramp_step_dec #(.UNIT_CYC(UNIT_CYC), .CNT_W(CNT_W)) u_dec (
        .idx       (idx),
        .tgt       (dec_tgt),
        .data      (dec_data),
        .dwell_cyc (dec_dwell)
    );

    clk_ramp_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dw_load),
        .load_val (dec_dwell),
        .zero     (dw_zero)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.src_wr  = 1'b0;
        seq_d.diva_wr = 1'b0;
        seq_d.divb_wr = 1'b0;
        dw_load       = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.done = 1'b0;
                dw_load    = 1'b1;
            end
        end else if (dw_zero) begin
            if (seq_q.step == STEP_W'(NUM_STEPS)) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                dw_load = 1'b1;
            end
        end
        if (dw_load) begin
            seq_d.step = idx + 1'b1;
            case (dec_tgt)
                TGT_SRC:  begin seq_d.src  = dec_data; seq_d.src_wr  = 1'b1; end
                TGT_DIVA: begin seq_d.diva = dec_data; seq_d.diva_wr = 1'b1; end
                TGT_DIVB: begin seq_d.divb = dec_data; seq_d.divb_wr = 1'b1; end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign done    = seq_q.done;
    assign src_sel = seq_q.src;
    assign src_wr  = seq_q.src_wr;
    assign diva    = seq_q.diva;
    assign diva_wr = seq_q.diva_wr;
    assign divb    = seq_q.divb;
    assign divb_wr = seq_q.divb_wr;

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_wr, diva_wr, divb_wr}));

    assert_wr_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr || diva_wr || divb_wr) |-> busy);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_diva_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        diva_wr || $stable(diva));

    assert_divb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        divb_wr || $stable(divb));

    assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src_wr || $stable(src_sel));

endmodule

// File: tb/clk_ramp_seq_tb.sv
module clk_ramp_seq_tb;

    localparam int U = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done;
    logic [7:0] src_sel, diva, divb;
    logic       src_wr, diva_wr, divb_wr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    tgt;
        int    data;
        int    cyc;
        string req;
    } exp_t;

    exp_t exp_q[$];

    clk_ramp_seq #(.UNIT_CYC(U)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done),
        .src_sel(src_sel), .src_wr(src_wr),
        .diva(diva), .diva_wr(diva_wr),
        .divb(divb), .divb_wr(divb_wr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare every strobe with the head of the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && (src_wr || diva_wr || divb_wr)) begin
            int    gt;
            int    gd;
            exp_t  e;
            gt = src_wr ? 1 : (diva_wr ? 2 : 3);
            gd = src_wr ? int'(src_sel) : (diva_wr ? int'(diva) : int'(divb));
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", $sformatf("tgt%0d=%02h", gt, gd), "no write");
            end else begin
                e = exp_q.pop_front();
                check(e.tgt == gt && e.data == gd && e.cyc == cyc &&
                      $countones({src_wr, diva_wr, divb_wr}) == 1,
                      {e.req, "/R6/R7"},
                      $sformatf("tgt%0d=%02h@%0d", gt, gd, cyc),
                      $sformatf("tgt%0d=%02h@%0d", e.tgt, e.data, e.cyc));
            end
        end
    end

    // Driver: pulse start and queue the expected writes; returns done cycle.
    task automatic launch(output int done_cyc);
        int tg[12] = '{1, 2, 3, 1, 2, 2, 2, 2, 3, 3, 3, 3};
        int dt[12] = '{'h34, 'hFF, 'hFF, 'h36, 'h77, 'h33, 'h11, 'h01, 'h77, 'h33, 'h11, 'h01};
        int un[12] = '{0, 0, 4, 4, 8, 8, 16, 16, 8, 8, 16, 16};
        int t;
        @(negedge clk);
        start = 1'b1;
        t = cyc + 1;
        for (int k = 0; k < 12; k++) begin
            exp_t e;
            e.tgt  = tg[k];
            e.data = dt[k];
            e.cyc  = t;
            e.req  = (k < 4) ? "R3" : ((k < 8) ? "R4" : "R5");
            exp_q.push_back(e);
            t = t + 1 + un[k] * U;
        end
        done_cyc = t;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2", $sformatf("busy%0b done%0b", busy, done), "busy1 done0");
    endtask

    task automatic finish_run(input int done_cyc);
        while (cyc < done_cyc - 1) @(negedge clk);
        check(busy && !done, "R8", $sformatf("busy%0b done%0b", busy, done), "busy1 done0 before end");
        @(negedge clk);
        check(!busy && done, "R8", $sformatf("busy%0b done%0b", busy, done), "busy0 done1");
        check(exp_q.size() == 0, "R9", $sformatf("%0d left", exp_q.size()), "0 left");
        check(src_sel == 8'h36 && diva == 8'h01 && divb == 8'h01, "R10",
              $sformatf("%02h %02h %02h", src_sel, diva, divb), "36 01 01");
    endtask

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        check(src_sel == 8'h00 && diva == 8'hFF && divb == 8'hFF && !busy && !done &&
              !src_wr && !diva_wr && !divb_wr, "R1",
              $sformatf("%02h %02h %02h b%0b d%0b", src_sel, diva, divb, busy, done),
              "00 FF FF b0 d0");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !src_wr, "R1", $sformatf("b%0b d%0b", busy, done), "idle");

        // Run 1 with extra start pulses while busy (R9).
        launch(dc);
        repeat (7) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        finish_run(dc);

        repeat (6) @(negedge clk);
        check(done && !busy && !src_wr && !diva_wr && !divb_wr, "R8",
              $sformatf("d%0b b%0b", done, busy), "done held, no writes");

        // Run 2 from the done state: start clears done.
        launch(dc);
        finish_run(dc);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && done, "R9", $sformatf("%0d left", exp_q.size()), "0 left");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule